// File: doc/BRIEF.md
# CAN Passive Error Flag Sequencer

This block runs the error-signalling tail of a CAN node after a fault or an overload condition has been decided elsewhere. A start strobe opens the sequence. The block selects one of three flag forms from a type select and the node's error-passive indication. The first form is a passive error flag, where the block keeps its own output recessive and listens. The second is an active error flag, six dominant bits. The third is an overload flag, also six dominant bits.

A passive flag is complete only when the sampled bus has held one value for six consecutive bit strobes. Every change of bus value restarts that run. After any flag, the block waits for a recessive bus bit, and that bit is the first bit of an eight-bit delimiter. If the bus stays dominant for too long while the block waits, it moves to a too-long state. There are two such states, one for error flags and one for overload flags, so the frame kind stays correct in the status outputs. A dominant bit inside the delimiter produces a one-cycle form-error strobe and ends the sequence. Error counting and frame decoding belong to neighbouring logic.

Top module: `pef_seq`

## Requirements
- R1: After reset the block is idle: phase_o is 0, tx_bit_o is 1 (recessive), and err_frame_o, ovr_frame_o, act_err_o, act_ovr_o and form_err_o are all 0.
- R2: A start_i pulse in idle chooses the flag form. With ovr_sel_i=1 the block sends an active overload flag. With ovr_sel_i=0 and err_passive_i=1 it sends a passive error flag. With ovr_sel_i=0 and err_passive_i=0 it sends an active error flag. The block ignores start_i in every state other than idle.
- R3: A passive error flag ends on the bit strobe that completes RUN_LEN (6) consecutive equal rx_bit_i samples. A change of value restarts the run at one. Dominant samples do not abort the flag.
- R4: An active flag drives tx_bit_o=0 for FLAG_LEN (6) bit strobes. During an active flag, act_err_o is 1 for an error flag and act_ovr_o is 1 for an overload flag.
- R5: During a passive flag, act_err_o and act_ovr_o are 0. tx_bit_o is 1 in every phase except the active flag.
- R6: After a flag the block waits until a strobe samples rx_bit_i=1. That sample counts as the first delimiter bit.
- R7: If the bus stays dominant for LONG_LIMIT (7) strobes while the block waits, it enters the error too-long state (for error flags) or the overload too-long state (for overload flags). It leaves that state for the delimiter on the first recessive sample.
- R8: err_frame_o is 1 from the start of an error flag through the end of its delimiter, and ovr_frame_o does the same for an overload flag. The two are never 1 together.
- R9: The delimiter lasts DELIM_LEN (8) recessive strobes, after which the block returns to idle.
- R10: A dominant sample inside the delimiter pulses form_err_o for exactly one cycle and returns the block to idle.
- R11: The phase_o encoding is: 0 idle, 1 passive flag, 2 active flag, 3 wait for recessive, 4 error too long, 5 overload too long, 6 delimiter. phase_o changes only in the cycle after a bit_stb_i or start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | One-cycle strobe at each bit sample point |
| rx_bit_i | input | 1 | Sampled bus value, 1 is recessive |
| start_i | input | 1 | Opens a flag sequence |
| err_passive_i | input | 1 | Node is error passive |
| ovr_sel_i | input | 1 | 1 selects an overload flag, 0 an error flag |
| tx_bit_o | output | 1 | Transmit bit, 1 is recessive |
| phase_o | output | 3 | Current phase, encoding in R11 |
| err_frame_o | output | 1 | Error frame in progress |
| ovr_frame_o | output | 1 | Overload frame in progress |
| act_err_o | output | 1 | Active error flag being driven |
| act_ovr_o | output | 1 | Overload flag being driven |
| form_err_o | output | 1 | One-cycle form-error strobe from the delimiter |

## Verification
The assertions check these properties on every cycle: the transmit output is recessive outside the active flag, the active indications are silent during a passive flag, and the frame-kind outputs exclude each other. They also check that the form-error strobe lasts a single cycle and follows the delimiter, that the delimiter is entered only on a recessive sample, and that the phase moves only on a strobe or start. The bench scenarios show the counted lengths: the equal-run restart, the six-bit active flag, the seven-bit too-long threshold and the eight-bit delimiter. They also show that a start arriving mid-sequence is ignored.

// File: rtl/pef_pkg.sv
package pef_pkg;
  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_PFLAG    = 3'd1,
    PH_AFLAG    = 3'd2,
    PH_WAIT     = 3'd3,
    PH_ERR_LONG = 3'd4,
    PH_OVR_LONG = 3'd5,
    PH_DELIM    = 3'd6
  } pef_phase_e;
endpackage

// File: rtl/pef_run_det.sv
// Tracks the run of equal sampled bits; done_o flags the strobe completing RUN_LEN.
module pef_run_det #(
  parameter int RUN_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic bit_i,
  output logic done_o
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] RUN_END = RW'(RUN_LEN);

  logic [RW-1:0] cnt_q, cnt_nx;
  logic          last_q;

  always_comb begin
    if (cnt_q != '0 && bit_i == last_q) cnt_nx = cnt_q + 1'b1;
    else                                cnt_nx = RW'(1);
  end

  assign done_o = en_i && (cnt_nx == RUN_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= 1'b1;
    end else if (clr_i) begin
      cnt_q  <= '0;
      last_q <= 1'b1;
    end else if (en_i) begin
      cnt_q  <= cnt_nx;
      last_q <= bit_i;
    end
  end
endmodule

// File: rtl/pef_bit_cnt.sv
// Shared bit counter for active flag, dominant wait and delimiter.
module pef_bit_cnt #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ld1_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (ld1_i)  cnt_o <= CW'(1);
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pef_seq.sv
module pef_seq
  import pef_pkg::*;
#(
  parameter int FLAG_LEN   = 6,
  parameter int RUN_LEN    = 6,
  parameter int DELIM_LEN  = 8,
  parameter int LONG_LIMIT = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_stb_i,
  input  logic       rx_bit_i,
  input  logic       start_i,
  input  logic       err_passive_i,
  input  logic       ovr_sel_i,
  output logic       tx_bit_o,
  output logic [2:0] phase_o,
  output logic       err_frame_o,
  output logic       ovr_frame_o,
  output logic       act_err_o,
  output logic       act_ovr_o,
  output logic       form_err_o
);
  localparam int MAX_A = (FLAG_LEN > DELIM_LEN) ? FLAG_LEN : DELIM_LEN;
  localparam int MAX_L = (MAX_A > LONG_LIMIT) ? MAX_A : LONG_LIMIT;
  localparam int CW    = $clog2(MAX_L + 1);
  localparam logic [CW-1:0] FLAG_LAST  = CW'(FLAG_LEN - 1);
  localparam logic [CW-1:0] DELIM_LAST = CW'(DELIM_LEN - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_LIMIT - 1);

  pef_phase_e    state_q, state_nx;
  logic          ovr_q, ovr_nx;
  logic          form_q, form_nx;
  logic          cnt_clr, cnt_ld1, cnt_inc;
  logic [CW-1:0] cnt;
  logic          run_done;

  pef_run_det #(.RUN_LEN(RUN_LEN)) i_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == PH_IDLE),
    .en_i   (bit_stb_i && state_q == PH_PFLAG),
    .bit_i  (rx_bit_i),
    .done_o (run_done)
  );

  pef_bit_cnt #(.CW(CW)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .ld1_i  (cnt_ld1),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt)
  );

  always_comb begin
    state_nx = state_q;
    ovr_nx   = ovr_q;
    form_nx  = 1'b0;
    cnt_clr  = 1'b0;
    cnt_ld1  = 1'b0;
    cnt_inc  = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (start_i) begin
          cnt_clr = 1'b1;
          ovr_nx  = ovr_sel_i;
          if (!ovr_sel_i && err_passive_i) state_nx = PH_PFLAG;
          else                             state_nx = PH_AFLAG;
        end
      end
      PH_AFLAG: begin
        if (bit_stb_i) begin
          if (cnt == FLAG_LAST) begin
            state_nx = PH_WAIT;
            cnt_clr  = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      PH_PFLAG: begin
        if (run_done) begin
          state_nx = PH_WAIT;
          cnt_clr  = 1'b1;
        end
      end
      PH_WAIT: begin
        if (bit_stb_i) begin
          if (rx_bit_i) begin
            state_nx = PH_DELIM;
            cnt_ld1  = 1'b1;
          end else if (cnt == LONG_LAST) begin
            state_nx = ovr_q ? PH_OVR_LONG : PH_ERR_LONG;
            cnt_clr  = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      PH_ERR_LONG, PH_OVR_LONG: begin
        if (bit_stb_i && rx_bit_i) begin
          state_nx = PH_DELIM;
          cnt_ld1  = 1'b1;
        end
      end
      PH_DELIM: begin
        if (bit_stb_i) begin
          if (!rx_bit_i) begin
            state_nx = PH_IDLE;
            form_nx  = 1'b1;
            cnt_clr  = 1'b1;
          end else if (cnt == DELIM_LAST) begin
            state_nx = PH_IDLE;
            cnt_clr  = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      default: state_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      ovr_q   <= 1'b0;
      form_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      ovr_q   <= ovr_nx;
      form_q  <= form_nx;
    end
  end

  logic busy;
  assign busy        = (state_q != PH_IDLE);
  assign tx_bit_o    = (state_q != PH_AFLAG);
  assign phase_o     = state_q;
  assign err_frame_o = busy && !ovr_q && (state_q != PH_OVR_LONG);
  assign ovr_frame_o = busy && ovr_q && (state_q != PH_ERR_LONG);
  assign act_err_o   = (state_q == PH_AFLAG) && !ovr_q;
  assign act_ovr_o   = (state_q == PH_AFLAG) && ovr_q;
  assign form_err_o  = form_q;
endmodule

// File: rtl/pef_seq_chk.sv
module pef_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_stb_i,
  input logic       rx_bit_i,
  input logic       start_i,
  input logic       tx_bit_o,
  input logic [2:0] phase_o,
  input logic       err_frame_o,
  input logic       ovr_frame_o,
  input logic       act_err_o,
  input logic       act_ovr_o,
  input logic       form_err_o
);
  a_r5_tx_recessive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 3'd2) |-> tx_bit_o);

  a_r5_passive_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd1) |-> (!act_err_o && !act_ovr_o));

  a_r8_kind_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_frame_o && ovr_frame_o));

  a_r7_err_long_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd4) |-> (err_frame_o && !ovr_frame_o));

  a_r10_form_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    form_err_o |=> !form_err_o);

  a_r10_form_from_delim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(form_err_o) |-> (phase_o == 3'd0 && $past(phase_o) == 3'd6 && !$past(rx_bit_i)));

  a_r6_delim_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd6 && $past(phase_o) != 3'd6) |-> ($past(rx_bit_i) && $past(bit_stb_i)));

  a_r11_phase_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(bit_stb_i) && !$past(start_i)) |-> $stable(phase_o));
endmodule

bind pef_seq pef_seq_chk i_chk (.*);

// File: tb/test_pef_seq.sv
module test_pef_seq;
  localparam time CLK_P = 5ns;
  localparam int P_IDLE = 0, P_PFLAG = 1, P_AFLAG = 2, P_WAIT = 3,
                 P_ELONG = 4, P_OLONG = 5, P_DELIM = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic bit_stb_i = 1'b0, rx_bit_i = 1'b1, start_i = 1'b0;
  logic err_passive_i = 1'b0, ovr_sel_i = 1'b0;
  logic tx_bit_o, err_frame_o, ovr_frame_o, act_err_o, act_ovr_o, form_err_o;
  logic [2:0] phase_o;
  int checks = 0, failures = 0;

  always #(CLK_P / 2) clk_i = ~clk_i;

  pef_seq i_pef_seq (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(logic v);
    @(negedge clk_i);
    rx_bit_i  = v;
    bit_stb_i = 1'b1;
    @(negedge clk_i);
    bit_stb_i = 1'b0;
  endtask

  task automatic do_start(logic ovr, logic pas);
    @(negedge clk_i);
    ovr_sel_i     = ovr;
    err_passive_i = pas;
    start_i       = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // From WAIT: full recessive delimiter back to idle
  task automatic finish_delim(string req);
    send_bit(1'b1);
    check({req, " delim entered"}, phase_o, P_DELIM);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    check({req, " R9 delim bit 7"}, phase_o, P_DELIM);
    send_bit(1'b1);
    check({req, " R9 idle after 8"}, phase_o, P_IDLE);
    check({req, " R9 no form err"}, form_err_o, 0);
  endtask

  task automatic t_reset();
    check("R1 phase", phase_o, P_IDLE);
    check("R1 tx", tx_bit_o, 1);
    check("R1 status", {err_frame_o, ovr_frame_o, act_err_o, act_ovr_o, form_err_o}, 0);
  endtask

  task automatic t_passive_steady();
    do_start(1'b0, 1'b1);
    check("R2 passive chosen", phase_o, P_PFLAG);
    check("R8 err_frame", err_frame_o, 1);
    check("R5 act quiet", {act_err_o, act_ovr_o}, 0);
    check("R5 tx recessive", tx_bit_o, 1);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    check("R3 not done at 5", phase_o, P_PFLAG);
    send_bit(1'b1);
    check("R3 done at 6", phase_o, P_WAIT);
    finish_delim("R6");
  endtask

  task automatic t_passive_restart();
    do_start(1'b0, 1'b1);
    send_bit(1'b1); send_bit(1'b1);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    check("R3 restart after change", phase_o, P_PFLAG);
    check("R5 tx during dominant", tx_bit_o, 1);
    send_bit(1'b0);
    check("R3 six dominant completes", phase_o, P_WAIT);
    send_bit(1'b0);
    check("R6 waits on dominant", phase_o, P_WAIT);
    finish_delim("R6 restart");
  endtask

  task automatic t_active_err();
    do_start(1'b0, 1'b0);
    check("R2 active error chosen", phase_o, P_AFLAG);
    check("R4 tx dominant", tx_bit_o, 0);
    check("R4 act_err", {act_err_o, act_ovr_o}, 2);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    check("R4 still flag at 5", phase_o, P_AFLAG);
    send_bit(1'b0);
    check("R4 flag ends at 6", phase_o, P_WAIT);
    check("R5 tx after flag", tx_bit_o, 1);
    finish_delim("R4");
  endtask

  task automatic t_active_ovr();
    do_start(1'b1, 1'b1);
    check("R2 overload active", phase_o, P_AFLAG);
    check("R4 act_ovr", {act_err_o, act_ovr_o}, 1);
    check("R8 ovr_frame", {err_frame_o, ovr_frame_o}, 1);
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    check("R4 ovr flag done", phase_o, P_WAIT);
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    check("R7 not long at 6", phase_o, P_WAIT);
    send_bit(1'b0);
    check("R7 overload too long", phase_o, P_OLONG);
    check("R8 ovr kind in long", {err_frame_o, ovr_frame_o}, 1);
    finish_delim("R7 ovr");
  endtask

  task automatic t_err_long();
    do_start(1'b0, 1'b1);
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    check("R7 error too long", phase_o, P_ELONG);
    check("R8 err kind in long", {err_frame_o, ovr_frame_o}, 2);
    send_bit(1'b0);
    check("R7 long holds on dominant", phase_o, P_ELONG);
    finish_delim("R7 err");
  endtask

  task automatic t_form_err();
    do_start(1'b0, 1'b1);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b0);
    check("R10 form strobe", form_err_o, 1);
    check("R10 idle after form", phase_o, P_IDLE);
    @(negedge clk_i);
    check("R10 strobe one cycle", form_err_o, 0);
  endtask

  task automatic t_start_ignored();
    do_start(1'b0, 1'b1);
    do_start(1'b1, 1'b0);
    check("R2 start ignored phase", phase_o, P_PFLAG);
    check("R2 start ignored kind", ovr_frame_o, 0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    check("R2 flag kept", phase_o, P_WAIT);
    finish_delim("R2");
  endtask

  task automatic t_no_strobe();
    do_start(1'b0, 1'b1);
    repeat (10) @(negedge clk_i);
    check("R11 no strobe no move", phase_o, P_PFLAG);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    finish_delim("R11");
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_passive_steady();
    t_passive_restart();
    t_active_err();
    t_active_ovr();
    t_err_long();
    t_form_err();
    t_start_ignored();
    t_no_strobe();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule